// File: doc/BRIEF.md
# Shared Interrupt Router

The block collects a parameterized number of external interrupt sources (a multiple of eight, up to 256) and delivers them to a set of processor contexts. Each source can be sensed as an active-high or active-low level, or as a rising, falling or two-sided edge. Edge events are held in a per-source latch until software clears them. The same command register that clears a latch can also set it. This lets one context post a software interrupt to another context.

Software sees a flat 32-bit register file with single-cycle writes and combinational reads. Per-source bitmaps hold 32 sources per word, and their word addresses step by four bytes. Source `i` sits in word `i/32` at bit `i%32`. Each source is enabled by writing a one to a set-mask word and disabled by writing a one to a clear-mask word. Each source has its own route register that names the single context it drives. Each context has one output line. That line is the registered OR of every source that is pending, enabled and routed to that context.

Top module: `shared_irq_router`

## Requirements
- R1: After reset, every polarity bit reads 1, every trigger and two-edge bit reads 0, every mask bit reads 0, every latch is clear, every route reads 0 and every context output is low.
- R2: The read-only word at 0x000 returns NUM_SRC/8-1 in bits [7:0] and NUM_CTX-1 in bits [15:8]. All other bits read 0.
- R3: Writing a word at 0x0C0+4w sets the mask bit of each source whose bit is 1. Writing at 0x0E0+4w clears the mask bit of each such source. Zero bits leave the mask unchanged. The current mask reads back at 0x0A0+4w, and the mask changes in no other way.
- R4: A source whose trigger bit is 0 (register 0x040+4w) is level-sensed. With polarity 1 (register 0x020+4w) it is pending while its input is high, and with polarity 0 while its input is low. Nothing is held. The pending word at 0x080+4w follows the input two clocks after the input changes.
- R5: A source whose trigger bit is 1 and whose two-edge bit is 0 sets its latch on a rising input edge when polarity is 1, and on a falling edge when polarity is 0. Pending then stays 1 until the latch is cleared.
- R6: With the trigger bit and the two-edge bit (register 0x060+4w) both 1, every input transition sets the latch, whatever the polarity.
- R7: A write to 0x004 with bit 31 = 1 sets the latch of the source numbered in bits [7:0]. With bit 31 = 0 the write clears that latch. A number at or above NUM_SRC changes nothing. An edge detected in the same cycle as a clear leaves the latch set. A latch never sets without a detected edge or a set command.
- R8: The route register of source i at 0x100+4i takes a context number in its low bits. A written value at or above NUM_CTX is ignored.
- R9: Context output c goes high one clock after some source is pending, enabled and routed to c, and is low otherwise. Disabled sources never drive an output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_SRC | Asynchronous interrupt source lines |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 11 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| ctx_irq | output | NUM_CTX | One interrupt line per context |

## Verification
The assertions assume that every register write is word-aligned and lasts exactly one cycle. They also assume that the mask words are touched only through the set and clear addresses. The bench drives the bus from tasks that raise the strobe for exactly one clock at aligned addresses. The latch-origin property assumes that source 0 sees no command write whenever no write is present. Inputs change only at falling clock edges and are held for several cycles, so each transition passes through the synchronizer as a single clean edge. The bench sweeps every source of a 16-source, 4-context configuration through the mask, level, edge, two-edge and routing cases.

// File: rtl/shared_irq_router.sv
module shared_irq_router #(
  parameter int NUM_SRC = 16,
  parameter int NUM_CTX = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic               bus_wr,
  input  logic [10:0]        bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic [NUM_CTX-1:0] ctx_irq
);

  localparam int CTX_W = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1;
  localparam logic [10:0] A_CFG = 11'h000;
  localparam logic [10:0] A_CMD = 11'h004;

  logic [NUM_SRC-1:0] s1, s2, s3;
  logic [NUM_SRC-1:0] pol, trig, dual, mask, latch;
  logic [NUM_SRC-1:0] wsel, wbits, edge_hit, level_act, pend, cmd_vec;
  logic [CTX_W-1:0]   route [NUM_SRC];
  logic [NUM_CTX-1:0] ctx_next;

  wire       aligned  = (bus_addr[1:0] == 2'b00);
  wire [2:0] word     = bus_addr[4:2];
  wire       bm_space = aligned && (bus_addr[10:8] == 3'd0);
  wire       wr_bm    = bus_wr && bm_space;
  wire       wr_pol   = wr_bm && (bus_addr[7:5] == 3'd1);
  wire       wr_trig  = wr_bm && (bus_addr[7:5] == 3'd2);
  wire       wr_dual  = wr_bm && (bus_addr[7:5] == 3'd3);
  wire       wr_set   = wr_bm && (bus_addr[7:5] == 3'd6);
  wire       wr_clr   = wr_bm && (bus_addr[7:5] == 3'd7);
  wire [8:0] route_idx = bus_addr[10:2] - 9'd64;
  wire       rt_space = aligned && (bus_addr[10:8] != 3'd0);
  wire       rt_ok    = bus_wdata < 32'(NUM_CTX);
  wire       cmd_hit  = bus_wr && (bus_addr == A_CMD) && ({1'b0, bus_wdata[7:0]} < 9'(NUM_SRC));
  wire       cmd_set  = bus_wdata[31];

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      wsel[i]  = (3'(i / 32) == word);
      wbits[i] = bus_wdata[i % 32];
    end
  end

  assign cmd_vec   = cmd_hit ? ({{(NUM_SRC-1){1'b0}}, 1'b1} << bus_wdata[7:0]) : '0;
  assign level_act = ~(s2 ^ pol);
  assign edge_hit  = trig & ((dual & (s2 ^ s3)) |
                             (~dual & pol & s2 & ~s3) |
                             (~dual & ~pol & ~s2 & s3));
  assign pend      = (trig & latch) | (~trig & level_act);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else begin
      s1 <= irq_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pol  <= '1;
      trig <= '0;
      dual <= '0;
      mask <= '0;
    end else begin
      if (wr_pol)  pol  <= (pol  & ~wsel) | (wbits & wsel);
      if (wr_trig) trig <= (trig & ~wsel) | (wbits & wsel);
      if (wr_dual) dual <= (dual & ~wsel) | (wbits & wsel);
      if (wr_set)  mask <= mask | (wsel & wbits);
      if (wr_clr)  mask <= mask & ~(wsel & wbits);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch <= '0;
    end else begin
      latch <= (latch & ~(cmd_vec & {NUM_SRC{~cmd_set}}))
             | (cmd_vec & {NUM_SRC{cmd_set}})
             | edge_hit;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_SRC; i++) begin
      if (!rst_n)
        route[i] <= '0;
      else if (bus_wr && rt_space && rt_ok && route_idx == 9'(i))
        route[i] <= bus_wdata[CTX_W-1:0];
    end
  end

  always_comb begin
    ctx_next = '0;
    for (int c = 0; c < NUM_CTX; c++)
      for (int i = 0; i < NUM_SRC; i++)
        if (pend[i] && mask[i] && route[i] == CTX_W'(c))
          ctx_next[c] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctx_irq <= '0;
    else        ctx_irq <= ctx_next;
  end

  function automatic logic [31:0] pick(input logic [NUM_SRC-1:0] v, input logic [2:0] w);
    logic [255:0] p;
    p = '0;
    p[NUM_SRC-1:0] = v;
    return p[{w, 5'b0} +: 32];
  endfunction

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_CFG) begin
      bus_rdata = {16'b0, 8'(NUM_CTX - 1), 8'(NUM_SRC / 8 - 1)};
    end else if (rt_space) begin
      for (int i = 0; i < NUM_SRC; i++)
        if (route_idx == 9'(i))
          bus_rdata = {{(32-CTX_W){1'b0}}, route[i]};
    end else if (bm_space) begin
      case (bus_addr[7:5])
        3'd1:    bus_rdata = pick(pol, word);
        3'd2:    bus_rdata = pick(trig, word);
        3'd3:    bus_rdata = pick(dual, word);
        3'd4:    bus_rdata = pick(pend, word);
        3'd5:    bus_rdata = pick(mask, word);
        default: bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/irq_router_checker.sv
module irq_router_checker #(
  parameter int NUM_SRC = 16,
  parameter int NUM_CTX = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_wr,
  input logic [10:0]        bus_addr,
  input logic [31:0]        bus_wdata,
  input logic [NUM_SRC-1:0] mask,
  input logic [NUM_SRC-1:0] latch,
  input logic [NUM_SRC-1:0] trig,
  input logic [NUM_CTX-1:0] ctx_irq
);

  assert_setmask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 11'h0C0 && bus_wdata[0]) |=> mask[0]);

  assert_clrmask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 11'h0E0 && bus_wdata[0]) |=> !mask[0]);

  assert_mask_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(mask));

  assert_latch_origin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr && !trig[0] && !latch[0]) |=> !latch[0]);

  assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |=> (ctx_irq == '0));

endmodule

bind shared_irq_router irq_router_checker #(.NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .mask(mask), .latch(latch), .trig(trig), .ctx_irq(ctx_irq)
);

// File: tb/tb_shared_irq_router.sv
`timescale 1ns/1ps
module tb_shared_irq_router;
  localparam int NS = 16;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] irq_in = '0;
  logic          bus_wr = 1'b0;
  logic [10:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NC-1:0] ctx_irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] rv;
  logic [31:0] exp;

  always #2.5 clk = ~clk;

  shared_irq_router #(.NUM_SRC(NS), .NUM_CTX(NC)) dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctx_irq(ctx_irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, expv);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [10:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [10:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
    bus_addr = '0;
  endtask

  task automatic rchk(input logic [10:0] a, input logic [31:0] e, input string req);
    logic [31:0] v;
    rd(a, v);
    chk(v == e, req, v, e);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);

    rchk(11'h020, 32'h0000FFFF, "R1 pol");
    rchk(11'h040, 32'h0, "R1 trig");
    rchk(11'h060, 32'h0, "R1 dual");
    rchk(11'h0A0, 32'h0, "R1 mask");
    rchk(11'h080, 32'h0, "R1 pend");
    chk(ctx_irq == '0, "R1 ctx", 32'(ctx_irq), 0);
    for (int i = 0; i < NS; i++) rchk(11'(11'h100 + 4*i), 32'h0, "R1 route");
    rchk(11'h000, {16'b0, 8'(NC-1), 8'(NS/8-1)}, "R2 config");

    exp = 0;
    for (int i = 0; i < NS; i += 2) begin
      wr(11'h0C0, 32'(1) << i);
      exp |= 32'(1) << i;
      rchk(11'h0A0, exp, "R3 set");
    end
    wr(11'h0C0, 32'h0);
    rchk(11'h0A0, exp, "R3 zero set");
    wr(11'h0C0, 32'h0000FFFF);
    rchk(11'h0A0, 32'h0000FFFF, "R3 set all");
    for (int i = 0; i < NS; i += 3) begin
      wr(11'h0E0, 32'(1) << i);
      rchk(11'h0A0, 32'h0000FFFF & ~(32'(1) << i), "R3 clr");
      wr(11'h0E0, 32'h0);
      rchk(11'h0A0, 32'h0000FFFF & ~(32'(1) << i), "R3 zero clr");
      wr(11'h0C0, 32'(1) << i);
    end

    irq_in = 16'h0001;
    step(2);
    rchk(11'h080, 32'h1, "R4 latency pend");
    chk(ctx_irq == 4'b0000, "R9 latency before", 32'(ctx_irq), 0);
    step(1);
    chk(ctx_irq == 4'b0001, "R9 latency after", 32'(ctx_irq), 1);
    for (int i = 0; i < NS; i++) begin
      irq_in = NS'(1) << i;
      step(4);
      rchk(11'h080, 32'(1) << i, "R4 level high");
      chk(ctx_irq == 4'b0001, "R9 level ctx", 32'(ctx_irq), 1);
    end
    irq_in = '0;
    step(4);
    rchk(11'h080, 32'h0, "R4 not held");
    wr(11'h020, 32'h0);
    step(1);
    rchk(11'h080, 32'h0000FFFF, "R4 active low idle");
    irq_in = '1;
    step(4);
    rchk(11'h080, 32'h0, "R4 active low driven");
    irq_in = '0;
    wr(11'h020, 32'h0000FFFF);
    step(4);

    for (int i = 0; i < NS; i++) wr(11'(11'h100 + 4*i), 32'(i % NC));
    for (int i = 0; i < NS; i++) begin
      irq_in = NS'(1) << i;
      step(4);
      chk(ctx_irq == NC'(1) << (i % NC), "R8 R9 routed", 32'(ctx_irq), 32'(1) << (i % NC));
    end
    wr(11'h10C, 32'd4);
    rchk(11'h10C, 32'd3, "R8 bad route ignored");
    irq_in = 16'h0008;
    wr(11'h0E0, 32'h8);
    step(4);
    rchk(11'h080, 32'h8, "R9 masked pend");
    chk(ctx_irq == '0, "R9 masked quiet", 32'(ctx_irq), 0);
    wr(11'h0C0, 32'h8);
    step(2);
    chk(ctx_irq == 4'b1000, "R9 unmasked", 32'(ctx_irq), 8);
    irq_in = '0;
    for (int i = 0; i < NS; i++) wr(11'(11'h100 + 4*i), 32'h0);
    step(4);

    wr(11'h040, 32'h0000FFFF);
    exp = 0;
    for (int i = 0; i < NS; i++) begin
      irq_in = NS'(1) << i;
      step(3);
      irq_in = '0;
      step(4);
      exp |= 32'(1) << i;
      rchk(11'h080, exp, "R5 rising held");
    end
    chk(ctx_irq == 4'b0001, "R9 edge ctx", 32'(ctx_irq), 1);
    for (int i = 0; i < NS; i++) begin
      wr(11'h004, 32'(i));
      exp &= ~(32'(1) << i);
      rchk(11'h080, exp, "R7 clear");
    end
    wr(11'h020, 32'h0);
    irq_in = '1;
    step(5);
    rchk(11'h080, 32'h0, "R5 rise ignored when falling");
    irq_in = '0;
    step(5);
    rchk(11'h080, 32'h0000FFFF, "R5 falling latched");
    for (int i = 0; i < NS; i++) wr(11'h004, 32'(i));
    rchk(11'h080, 32'h0, "R7 clear all");

    wr(11'h060, 32'h0000FFFF);
    irq_in = '1;
    step(5);
    rchk(11'h080, 32'h0000FFFF, "R6 rise pol0");
    for (int i = 0; i < NS; i++) wr(11'h004, 32'(i));
    irq_in = '0;
    step(5);
    rchk(11'h080, 32'h0000FFFF, "R6 fall pol0");
    for (int i = 0; i < NS; i++) wr(11'h004, 32'(i));
    wr(11'h020, 32'h0000FFFF);
    irq_in = 16'h00F0;
    step(5);
    rchk(11'h080, 32'h000000F0, "R6 rise pol1");
    for (int i = 0; i < NS; i++) wr(11'h004, 32'(i));
    irq_in = '0;
    step(5);
    rchk(11'h080, 32'h000000F0, "R6 fall pol1");
    for (int i = 0; i < NS; i++) wr(11'h004, 32'(i));
    wr(11'h060, 32'h0);
    step(2);

    wr(11'h004, 32'h80000005);
    rchk(11'h080, 32'h20, "R7 set");
    step(1);
    chk(ctx_irq == 4'b0001, "R7 R9 soft ctx", 32'(ctx_irq), 1);
    wr(11'h004, 32'h80000010);
    rchk(11'h080, 32'h20, "R7 out of range set");
    wr(11'h004, 32'h00000015);
    rchk(11'h080, 32'h20, "R7 out of range clear");
    wr(11'h004, 32'h00000005);
    rchk(11'h080, 32'h0, "R7 soft clear");

    wr(11'h004, 32'h80000002);
    irq_in = 16'h0004;
    step(2);
    wr(11'h004, 32'h00000002);
    rchk(11'h080, 32'h4, "R7 edge beats clear");
    irq_in = '0;
    step(4);
    wr(11'h004, 32'h00000002);
    rchk(11'h080, 32'h0, "R7 final clear");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog: got %h expected %h", 32'h1, 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule